// File: doc/BRIEF.md
# I2C Target for an 8-bit Register Bank

This block lets an I2C host read and write a bank of 8-bit registers that sits beside it on the chip. SCL and SDA are sampled with the system clock. The block detects START, repeated START and STOP on the sampled lines and answers only to its own 7-bit device address. A write transaction first loads an internal register pointer and then stores data bytes. A read transaction returns bytes starting at the pointer. The pointer steps forward after every byte in both directions, so bursts reach consecutive registers.

The pointer is kept from one transaction to the next. A read is therefore two transactions: a write that carries only the pointer byte, then a read. These may also be joined by a repeated START. SDA is driven through an open-drain enable, so the pad pulls low only while `sda_oe_o` is high. The register bank is reached through a plain port: address, write data and a one-cycle write strobe, with read data returned combinationally. If SDA stays low too long, a timeout releases the line and returns the protocol logic to idle.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After a START, a first byte whose upper seven bits equal DEV_ADDR is acknowledged by pulling SDA low during the ninth SCL pulse. The lowest bit of that byte selects the direction: 0 is write, 1 is read. A byte with any other address gets no acknowledge, and SDA stays released until the next START or STOP.
- R2: In a write transaction, the byte after the address acknowledge is acknowledged and loaded into the register pointer without a write strobe.
- R3: Each later byte of a write transaction is acknowledged. It produces one single-cycle `reg_we_o` pulse with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte. The pointer then advances by one.
- R4: The pointer wraps from 0xFF to 0x00 in both directions.
- R5: The pointer persists across transactions. A read transaction returns the register at the pointer, most significant bit first, and the driven level does not change while SCL is high.
- R6: In a read burst, each byte acknowledged by the host is followed by the register at the next address. The pointer advances after every byte sent, including the last one.
- R7: After the host does not acknowledge a read byte, the block keeps SDA released until the next START or STOP.
- R8: A repeated START at any point restarts the address phase.
- R9: A STOP, including one in the middle of a byte, releases SDA, returns the block to idle and leaves the pointer unchanged.
- R10: If sampled SDA stays low for TIMEOUT_CYCLES consecutive clock cycles, SDA is released and the block returns to idle, ignoring the bus until the next START. The count is cleared whenever SDA is high or a START or STOP is seen.
- R11: After reset, SDA is released, `reg_we_o` is low and the pointer (`reg_addr_o`) is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sda_oe_o | output | 1 | High pulls SDA low |
| reg_addr_o | output | 8 | Register pointer / bank address |
| reg_wdata_o | output | 8 | Write data to the bank |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_rdata_i | input | 8 | Read data from the bank at `reg_addr_o` |

## Verification
The bench keeps the default device address and two synchronizer stages. It lowers TIMEOUT_CYCLES to 2000 cycles, which is still above the longest legitimate low stretch the bench produces, about 1300 cycles for a burst of zero bytes at 20 clocks per SCL bit. The lower value puts the stuck-low release within a short run, and the bench checks it both before and after the threshold. With a 20-clock SCL period, the two-flop sampling delay fits inside each SCL-low phase, so the most significant bit of a read byte is already on the line before the first rising SCL edge of that byte.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_IGNORE
  } state_e;

endpackage

// File: rtl/i2c_rb_line_sync.sv
module i2c_rb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] scl_ff, sda_ff;
  logic          scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[LAST-1:0], scl_i};
          sda_ff <= {sda_ff[LAST-1:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_ff[LAST];
      sda_d <= sda_ff[LAST];
    end
  end

  assign scl_o      = scl_ff[LAST];
  assign sda_o      = sda_ff[LAST];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edges count as bus conditions only while SCL is steadily high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/i2c_rb_timeout.sv
module i2c_rb_timeout #(
  parameter int unsigned LIMIT = 2_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic start_i,
  input  logic stop_i,
  output logic expired_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          clear;

  assign clear = sda_i | start_i | stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clear)                  cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT))    cnt_q <= cnt_q + 1'b1;
  end

  // single pulse on reaching the limit; counter saturates afterwards
  assign expired_o = !clear && (cnt_q == CW'(LIMIT - 1));

  assert_timeout_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |=> !expired_o);

endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5A,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          timeout_i,
  input  logic [DW-1:0] rdata_i,
  output logic          sda_oe_o,
  output logic [DW-1:0] ptr_o,
  output logic [DW-1:0] wdata_o,
  output logic          we_o
);

  localparam int unsigned CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);

  state_e           state_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [DW-1:0]    shreg_q, tx_q, ptr_q, wdata_q;
  logic             we_q, rw_q, mack_q;
  logic             byte_done;

  assign byte_done = scl_fall_i && (bit_cnt_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      wdata_q   <= '0;
      we_q      <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (we_q) ptr_q <= ptr_q + 1'b1;

      if (timeout_i || stop_i) begin
        state_q <= ST_IDLE;
      end else if (start_i) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise_i) begin
              shreg_q   <= {shreg_q[DW-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (byte_done) begin
              bit_cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (shreg_q[DW-1:1] == DEV_ADDR) begin
                  rw_q    <= shreg_q[0];
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IGNORE;
                end
              end else if (state_q == ST_PTR) begin
                ptr_q   <= shreg_q;
                state_q <= ST_PTR_ACK;
              end else begin
                wdata_q <= shreg_q;
                we_q    <= 1'b1;
                state_q <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              if (rw_q) begin
                tx_q    <= rdata_i;
                state_q <= ST_RDATA;
              end else begin
                state_q <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK, ST_WDATA_ACK: begin
            if (scl_fall_i) state_q <= ST_WDATA;
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (byte_done) begin
              bit_cnt_q <= '0;
              ptr_q     <= ptr_q + 1'b1;
              state_q   <= ST_RDATA_ACK;
            end else if (scl_fall_i) begin
              tx_q <= {tx_q[DW-2:0], 1'b0};
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                tx_q    <= rdata_i;
                state_q <= ST_RDATA;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
      ST_RDATA:                              sda_oe_o = ~tx_q[DW-1];
      default:                               sda_oe_o = 1'b0;
    endcase
  end

  assign ptr_o   = ptr_q;
  assign wdata_o = wdata_q;
  assign we_o    = we_q;

  assert_we_advances_ptr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> (ptr_q == $past(ptr_q) + 1'b1));

  assert_we_single_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q);

  assert_rdata_stable_scl_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RDATA && $past(state_q) == ST_RDATA && scl_i && $past(scl_i))
      |-> $stable(sda_oe_o));

  assert_stop_releases_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o);

  assert_timeout_releases_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> !sda_oe_o);

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter logic [6:0]  DEV_ADDR       = 7'h5A,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned TIMEOUT_CYCLES = 2_500_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_we_o,
  input  logic [7:0] reg_rdata_i
);

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop, timeout;

  i2c_rb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_rb_timeout #(.LIMIT(TIMEOUT_CYCLES)) u_timeout (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_i     (sda_s),
    .start_i   (start),
    .stop_i    (stop),
    .expired_o (timeout)
  );

  i2c_rb_engine #(.DEV_ADDR(DEV_ADDR), .DW(8)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .timeout_i  (timeout),
    .rdata_i    (reg_rdata_i),
    .sda_oe_o   (sda_oe_o),
    .ptr_o      (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .we_o       (reg_we_o)
  );

endmodule

// File: tb/tb_i2c_regbank_slave.sv
`timescale 1ns/1ps
module tb_i2c_regbank_slave;

  localparam logic [6:0] DEV = 7'h5A;
  localparam int TO = 2000;
  localparam int H  = 10;
  localparam int Q  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_bus, sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_regbank_slave #(.DEV_ADDR(DEV), .SYNC_STAGES(2), .TIMEOUT_CYCLES(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  function automatic logic [7:0] ptr_add(logic [7:0] p, int n);
    return p + 8'(n);
  endfunction

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ptr;
  logic [7:0] wbuf [8];
  int n_we = 0, n_oe = 0;
  int n_chk = 0, n_fail = 0;

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      n_we <= n_we + 1;
    end
  end

  always @(posedge clk) if (sda_oe) n_oe <= n_oe + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wclk(Q);
    scl = 1'b1;   wclk(H);
    sda_m = 1'b0; wclk(H);
    scl = 1'b0;   wclk(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wclk(Q);
    scl = 1'b1;   wclk(H);
    sda_m = 1'b1; wclk(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wclk(Q);
      scl = 1'b1;   wclk(H);
      scl = 1'b0;   wclk(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    sda_m = 1'b1; wclk(Q);
    scl = 1'b1;   wclk(H/2);
    acked = ~sda_bus;
    wclk(H/2);
    scl = 1'b0;   wclk(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wclk(Q);
      scl = 1'b1; wclk(H/2);
      b = {b[6:0], sda_bus};
      wclk(H/2);
      scl = 1'b0;
    end
    sda_m = ~give_ack; wclk(Q);
    scl = 1'b1;        wclk(H);
    scl = 1'b0;        wclk(Q);
    sda_m = 1'b1;
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(req, bad, 0);
  endtask

  task automatic wr_txn(input logic [7:0] p, input int n);
    logic a;
    int we0 = n_we;
    i2c_start();
    send_byte({DEV, 1'b0}, a); chk("R1 addr ack", a, 1);
    send_byte(p, a);           chk("R2 ptr ack", a, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a);   chk("R3 data ack", a, 1);
      exp_mem[ptr_add(p, k)] = wbuf[k];
    end
    i2c_stop();
    exp_ptr = ptr_add(p, n);
    chk("R3 strobe count", n_we - we0, n);
    chk("R3 ptr after write", reg_addr, exp_ptr);
    cmp_mem("R3/R4 bank contents");
  endtask

  task automatic rd_txn(input logic set_ptr, input logic [7:0] p, input int n);
    logic a;
    logic [7:0] d;
    i2c_start();
    if (set_ptr) begin
      send_byte({DEV, 1'b0}, a); chk("R1 addr ack", a, 1);
      send_byte(p, a);           chk("R2 ptr ack", a, 1);
      exp_ptr = p;
      i2c_start();  // repeated START (R8)
    end
    send_byte({DEV, 1'b1}, a);   chk("R8 read addr ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      chk(k == 0 ? "R5 read data" : "R6 burst data", d, exp_mem[exp_ptr]);
      exp_ptr = ptr_add(exp_ptr, 1);
    end
    i2c_stop();
    chk("R6 ptr after read", reg_addr, exp_ptr);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic a;
    logic [7:0] d;
    int oe0, we0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    exp_ptr = 8'h00;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);

    // R11 reset state
    chk("R11 sda released", sda_oe, 0);
    chk("R11 no strobe", reg_we, 0);
    chk("R11 ptr zero", reg_addr, 8'h00);

    // R5 read at reset pointer without setting it
    rd_txn(1'b0, 8'h00, 1);

    // R3 burst write, R6 burst read
    wbuf[0] = 8'h11; wbuf[1] = 8'h00; wbuf[2] = 8'hFF;
    wr_txn(8'h10, 3);
    rd_txn(1'b1, 8'h10, 3);

    // R4 wrap in both directions
    wbuf[0] = 8'hC3; wbuf[1] = 8'h3C; wbuf[2] = 8'h81; wbuf[3] = 8'h7E;
    wr_txn(8'hFE, 4);
    chk("R4 ptr wrapped", reg_addr, 8'h02);
    rd_txn(1'b1, 8'hFF, 3);

    // R5 pointer persists across transactions
    wr_txn(8'h40, 0);
    rd_txn(1'b0, 8'h00, 2);

    // R1 address mismatch: no ack, no drive, no write
    oe0 = n_oe; we0 = n_we;
    i2c_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a); chk("R1 mismatch nack", a, 0);
    send_byte(8'h00, a);               chk("R1 ignored byte nack", a, 0);
    send_byte(8'h00, a);
    i2c_stop();
    chk("R1 no drive when unaddressed", n_oe - oe0, 0);
    chk("R1 no write when unaddressed", n_we - we0, 0);
    rd_txn(1'b0, 8'h00, 1);

    // R7 NACK ends read; bus ignored afterwards
    i2c_start();
    send_byte({DEV, 1'b1}, a); chk("R7 addr ack", a, 1);
    recv_byte(1'b1, d); chk("R6 burst data", d, exp_mem[exp_ptr]); exp_ptr = ptr_add(exp_ptr, 1);
    recv_byte(1'b0, d); chk("R6 burst data", d, exp_mem[exp_ptr]); exp_ptr = ptr_add(exp_ptr, 1);
    oe0 = n_oe;
    recv_byte(1'b0, d);
    chk("R7 no drive after nack", n_oe - oe0, 0);
    chk("R7 bus idle high", d, 8'hFF);
    i2c_stop();
    chk("R6 ptr advanced past nacked byte", reg_addr, exp_ptr);

    // R9 STOP in the middle of the pointer byte
    i2c_start();
    send_byte({DEV, 1'b0}, a); chk("R9 addr ack", a, 1);
    send_bits(8'h00, 4);
    i2c_stop();
    wclk(4);
    chk("R9 released after stop", sda_oe, 0);
    chk("R9 ptr unchanged", reg_addr, exp_ptr);
    rd_txn(1'b0, 8'h00, 1);

    // R10 stuck-low timeout during address acknowledge
    i2c_start();
    send_bits({DEV, 1'b0}, 8);
    wclk(20);
    chk("R1 ack driven", sda_oe, 1);
    wclk(TO / 2);
    chk("R10 still driven before limit", sda_oe, 1);
    wclk(TO);
    chk("R10 released after limit", sda_oe, 0);
    oe0 = n_oe; we0 = n_we;
    sda_m = 1'b1; wclk(Q); scl = 1'b1; wclk(H); scl = 1'b0; wclk(Q);
    send_byte(8'h00, a);       chk("R10 idle after timeout", a, 0);
    chk("R10 no drive after timeout", n_oe - oe0, 0);
    chk("R10 no write after timeout", n_we - we0, 0);
    i2c_stop();
    wbuf[0] = 8'h5C;
    wr_txn(8'h80, 1);
    rd_txn(1'b1, 8'h80, 1);

    // constrained random bursts
    for (int it = 0; it < 8; it++) begin
      logic [7:0] p;
      int n, off;
      p = 8'($urandom);
      n = 1 + int'($urandom % 5);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      wr_txn(p, n);
      off = int'($urandom % n);
      rd_txn(1'b1, ptr_add(p, off), 1 + int'($urandom % 3));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule